// File: doc/BRIEF.md
# Memory Operation Ordering Unit

This block sits between an instruction scheduler and the memory pipeline of an out-of-order core. Every memory operation is entered in program order together with its age tag. A load goes into a load queue and a store goes into a store queue. The entry stays there until the memory pipeline reports that it has finished. In each cycle the block grants at most one load and at most one store. In each queue it picks the oldest entry that the ordering rules allow to execute.

The ordering model is relaxed. Stores stay in order with older stores and with older loads. A load may move ahead of older loads. A load may move ahead of older stores only when the no-alias input is high. An operation that has side effects is treated as a barrier, and its type comes from its load and store flags. A barrier takes one slot in each queue it touches. It is released only once it is the oldest entry in all of those queues. It is released in the cycle it is granted and never needs a completion. Address comparison, forwarding and caches are handled elsewhere.

Top module: `mem_order_unit`

## Requirements
- R1: A load takes one load-queue slot and a store takes one store-queue slot. `lq_full` / `sq_full` are high while the number of occupied slots is at or above the capacity limit. A limit parameter of 0 means the full physical depth is the limit.
- R2: An allocation is refused when a queue it needs is full. An operation that needs both queues is refused when either one is full, and it then takes no slot in either queue.
- R3: A store is not granted while any older entry in either queue has not yet been granted, whatever the value of `no_alias`.
- R4: With `no_alias` high, an older store does not hold back a load. With `no_alias` low, a load waits until every older store has been granted. The input acts in the same cycle.
- R5: Older loads that are granted but not yet completed do not hold back a younger load.
- R6: Flags {may_load, may_store, side_effect} are decoded as follows. {1,0,0} is a load. {0,1,0} is a store. {1,0,1} is a load barrier. {0,1,1} is a store barrier. {1,1,1} is a full barrier. {1,1,0} takes a plain entry in each queue. An operation with neither flag is dropped.
- R7: A barrier is granted only when no older entry remains in the queue or queues it occupies, and its slot is freed by that grant. The two halves of a full barrier are granted in the same cycle.
- R8: A younger load waits while an older load barrier or full barrier is present. A younger store waits while an older store barrier or full barrier is present.
- R9: Each queue grants at most one entry per cycle, choosing the oldest eligible entry. `ld_grant`/`st_grant` are one-hot over the slot index, and the `*_grant_age` outputs carry the age of the granted entry.
- R10: A completion bit on a granted slot frees that slot at the next clock edge.
- R11: After reset both queues are empty, no grant is asserted and neither full flag is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| no_alias | input | 1 | High: loads are assumed never to alias stores |
| alloc_valid | input | 1 | An operation is offered for allocation |
| alloc_may_load | input | 1 | The operation reads memory |
| alloc_may_store | input | 1 | The operation writes memory |
| alloc_side_effect | input | 1 | The operation has unmodelled side effects (barrier) |
| alloc_age | input | AGE_W | Program-order age tag; it increases modulo 2^AGE_W |
| ld_done | input | LQ_SLOTS | Per-slot completion of granted loads |
| st_done | input | SQ_SLOTS | Per-slot completion of granted stores |
| ld_grant | output | LQ_SLOTS | One-hot load-queue execute grant |
| ld_grant_age | output | AGE_W | Age of the granted load-queue entry |
| st_grant | output | SQ_SLOTS | One-hot store-queue execute grant |
| st_grant_age | output | AGE_W | Age of the granted store-queue entry |
| lq_full | output | 1 | Load queue is at its capacity |
| sq_full | output | 1 | Store queue is at its capacity |

## Verification
A full barrier has to be released from both queues in one cycle, and that can coincide with an ordinary grant decision. The test holds a full barrier behind a load that has been granted but not completed. It then completes that load so that the barrier becomes the oldest entry in both queues at the same edge. In the next cycle the test expects a grant in both queues with equal ages. In the cycle after that it expects a store grant while a younger load is still held back. A second pairing changes `no_alias` in a cycle where a load is otherwise ready, and the test expects the load grant to appear in that same cycle.

// File: rtl/mem_order_unit.sv
module mem_order_unit #(
  parameter int LQ_SLOTS = 8,
  parameter int SQ_SLOTS = 8,
  parameter int LQ_CAP   = 0,
  parameter int SQ_CAP   = 0,
  parameter int AGE_W    = 6
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                no_alias,
  input  logic                alloc_valid,
  input  logic                alloc_may_load,
  input  logic                alloc_may_store,
  input  logic                alloc_side_effect,
  input  logic [AGE_W-1:0]    alloc_age,
  input  logic [LQ_SLOTS-1:0] ld_done,
  input  logic [SQ_SLOTS-1:0] st_done,
  output logic [LQ_SLOTS-1:0] ld_grant,
  output logic [AGE_W-1:0]    ld_grant_age,
  output logic [SQ_SLOTS-1:0] st_grant,
  output logic [AGE_W-1:0]    st_grant_age,
  output logic                lq_full,
  output logic                sq_full
);

  localparam int LIW    = (LQ_SLOTS > 1) ? $clog2(LQ_SLOTS) : 1;
  localparam int SIW    = (SQ_SLOTS > 1) ? $clog2(SQ_SLOTS) : 1;
  localparam int LQ_LIM = (LQ_CAP == 0 || LQ_CAP > LQ_SLOTS) ? LQ_SLOTS : LQ_CAP;
  localparam int SQ_LIM = (SQ_CAP == 0 || SQ_CAP > SQ_SLOTS) ? SQ_SLOTS : SQ_CAP;

  logic [LQ_SLOTS-1:0] l_v, l_iss, l_bar, l_fb, l_ok;
  logic [SQ_SLOTS-1:0] s_v, s_iss, s_bar, s_fb, s_ok;
  logic [AGE_W-1:0]    l_age [LQ_SLOTS];
  logic [AGE_W-1:0]    s_age [SQ_SLOTS];
  logic [LIW-1:0]      l_best, l_free;
  logic [SIW-1:0]      s_best, s_free;
  logic                l_found, s_found;
  logic                want_l, want_s, take, is_fb;

  function automatic logic older(input logic [AGE_W-1:0] a, input logic [AGE_W-1:0] b);
    logic [AGE_W-1:0] d;
    d = a - b;
    return d[AGE_W-1];
  endfunction

  assign lq_full = ($countones(l_v) >= LQ_LIM);
  assign sq_full = ($countones(s_v) >= SQ_LIM);
  assign want_l  = alloc_valid & alloc_may_load;
  assign want_s  = alloc_valid & alloc_may_store;
  assign take    = (want_l | want_s) & ~(want_l & lq_full) & ~(want_s & sq_full);
  assign is_fb   = alloc_side_effect & alloc_may_load & alloc_may_store;

  always_comb begin
    l_free = '0;
    for (int i = LQ_SLOTS - 1; i >= 0; i--)
      if (!l_v[i]) l_free = LIW'(i);
    s_free = '0;
    for (int k = SQ_SLOTS - 1; k >= 0; k--)
      if (!s_v[k]) s_free = SIW'(k);
  end

  always_comb begin
    l_ok = '0;
    for (int i = 0; i < LQ_SLOTS; i++) begin
      if (l_v[i] && !l_iss[i]) begin
        l_ok[i] = 1'b1;
        if (l_bar[i]) begin
          for (int j = 0; j < LQ_SLOTS; j++)
            if (l_v[j] && older(l_age[j], l_age[i])) l_ok[i] = 1'b0;
          if (l_fb[i])
            for (int k = 0; k < SQ_SLOTS; k++)
              if (s_v[k] && older(s_age[k], l_age[i])) l_ok[i] = 1'b0;
        end else begin
          for (int j = 0; j < LQ_SLOTS; j++)
            if (l_v[j] && l_bar[j] && older(l_age[j], l_age[i])) l_ok[i] = 1'b0;
          for (int k = 0; k < SQ_SLOTS; k++)
            if (!no_alias && s_v[k] && !s_iss[k] && !s_bar[k] && older(s_age[k], l_age[i]))
              l_ok[i] = 1'b0;
        end
      end
    end
  end

  always_comb begin
    s_ok = '0;
    for (int k = 0; k < SQ_SLOTS; k++) begin
      if (s_v[k] && !s_iss[k]) begin
        s_ok[k] = 1'b1;
        if (s_bar[k]) begin
          for (int m = 0; m < SQ_SLOTS; m++)
            if (s_v[m] && older(s_age[m], s_age[k])) s_ok[k] = 1'b0;
          if (s_fb[k])
            for (int j = 0; j < LQ_SLOTS; j++)
              if (l_v[j] && older(l_age[j], s_age[k])) s_ok[k] = 1'b0;
        end else begin
          for (int m = 0; m < SQ_SLOTS; m++)
            if (s_v[m] && !s_iss[m] && older(s_age[m], s_age[k])) s_ok[k] = 1'b0;
          for (int j = 0; j < LQ_SLOTS; j++)
            if (l_v[j] && !l_iss[j] && older(l_age[j], s_age[k])) s_ok[k] = 1'b0;
        end
      end
    end
  end

  always_comb begin
    l_found = 1'b0;
    l_best  = '0;
    for (int i = 0; i < LQ_SLOTS; i++)
      if (l_ok[i] && (!l_found || older(l_age[i], l_age[l_best]))) begin
        l_found = 1'b1;
        l_best  = LIW'(i);
      end
    s_found = 1'b0;
    s_best  = '0;
    for (int k = 0; k < SQ_SLOTS; k++)
      if (s_ok[k] && (!s_found || older(s_age[k], s_age[s_best]))) begin
        s_found = 1'b1;
        s_best  = SIW'(k);
      end
  end

  always_comb begin
    ld_grant = '0;
    st_grant = '0;
    if (l_found) ld_grant[l_best] = 1'b1;
    if (s_found) st_grant[s_best] = 1'b1;
  end

  assign ld_grant_age = l_found ? l_age[l_best] : '0;
  assign st_grant_age = s_found ? s_age[s_best] : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      l_v <= '0; l_iss <= '0; l_bar <= '0; l_fb <= '0;
      for (int i = 0; i < LQ_SLOTS; i++) l_age[i] <= '0;
    end else begin
      for (int i = 0; i < LQ_SLOTS; i++) begin
        if (ld_grant[i]) begin
          if (l_bar[i]) l_v[i] <= 1'b0;
          else          l_iss[i] <= 1'b1;
        end
        if (ld_done[i] && l_v[i] && l_iss[i]) begin
          l_v[i]   <= 1'b0;
          l_iss[i] <= 1'b0;
        end
        if (take && want_l && l_free == LIW'(i)) begin
          l_v[i]   <= 1'b1;
          l_iss[i] <= 1'b0;
          l_bar[i] <= alloc_side_effect;
          l_fb[i]  <= is_fb;
          l_age[i] <= alloc_age;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s_v <= '0; s_iss <= '0; s_bar <= '0; s_fb <= '0;
      for (int k = 0; k < SQ_SLOTS; k++) s_age[k] <= '0;
    end else begin
      for (int k = 0; k < SQ_SLOTS; k++) begin
        if (st_grant[k]) begin
          if (s_bar[k]) s_v[k] <= 1'b0;
          else          s_iss[k] <= 1'b1;
        end
        if (st_done[k] && s_v[k] && s_iss[k]) begin
          s_v[k]   <= 1'b0;
          s_iss[k] <= 1'b0;
        end
        if (take && want_s && s_free == SIW'(k)) begin
          s_v[k]   <= 1'b1;
          s_iss[k] <= 1'b0;
          s_bar[k] <= alloc_side_effect;
          s_fb[k]  <= is_fb;
          s_age[k] <= alloc_age;
        end
      end
    end
  end

endmodule

// File: rtl/mem_order_chk.sv
module mem_order_chk #(
  parameter int LQ_SLOTS = 8,
  parameter int SQ_SLOTS = 8,
  parameter int AGE_W    = 6
) (
  input logic                clk,
  input logic                rst_n,
  input logic [LQ_SLOTS-1:0] ld_grant,
  input logic [SQ_SLOTS-1:0] st_grant,
  input logic [AGE_W-1:0]    ld_grant_age,
  input logic [AGE_W-1:0]    st_grant_age,
  input logic [LQ_SLOTS-1:0] ld_done,
  input logic [SQ_SLOTS-1:0] st_done,
  input logic                lq_full,
  input logic                sq_full,
  input logic [LQ_SLOTS-1:0] l_bar,
  input logic [LQ_SLOTS-1:0] l_fb,
  input logic [SQ_SLOTS-1:0] s_bar,
  input logic [SQ_SLOTS-1:0] s_fb
);

  a_r9_ld_single: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ld_grant));

  a_r9_st_single: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(st_grant));

  a_r7_full_pair: assert property (@(posedge clk) disable iff (!rst_n)
    (|(ld_grant & l_fb)) |-> ((|(st_grant & s_fb)) && st_grant_age == ld_grant_age));

  a_r2_lq_full_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (lq_full && ld_done == '0 && (ld_grant & l_bar) == '0) |=> lq_full);

  a_r2_sq_full_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (sq_full && st_done == '0 && (st_grant & s_bar) == '0) |=> sq_full);

endmodule

bind mem_order_unit mem_order_chk #(
  .LQ_SLOTS(LQ_SLOTS), .SQ_SLOTS(SQ_SLOTS), .AGE_W(AGE_W)
) u_chk (
  .clk(clk), .rst_n(rst_n),
  .ld_grant(ld_grant), .st_grant(st_grant),
  .ld_grant_age(ld_grant_age), .st_grant_age(st_grant_age),
  .ld_done(ld_done), .st_done(st_done),
  .lq_full(lq_full), .sq_full(sq_full),
  .l_bar(l_bar), .l_fb(l_fb), .s_bar(s_bar), .s_fb(s_fb)
);

// File: tb/sim_mem_order_unit.sv
`timescale 1ns/1ps
module sim_mem_order_unit;

  localparam int NROWS = 41;
  localparam logic [2:0] K_L = 3'd0, K_S = 3'd1, K_LB = 3'd2, K_SB = 3'd3, K_FB = 3'd4;

  // {no_alias, alloc, kind, age, done_ld_age, done_st_age, exp_ld_age, exp_st_age}; age 0 = none
  localparam logic [34:0] TAB [NROWS] = '{
    {1'b1,1'b1,K_L ,6'd1 ,6'd0 ,6'd0,6'd0 ,6'd0 },
    {1'b1,1'b1,K_S ,6'd2 ,6'd0 ,6'd0,6'd1 ,6'd0 },
    {1'b1,1'b1,K_L ,6'd3 ,6'd0 ,6'd0,6'd0 ,6'd2 },
    {1'b1,1'b1,K_S ,6'd4 ,6'd0 ,6'd0,6'd3 ,6'd0 },
    {1'b1,1'b1,K_LB,6'd5 ,6'd0 ,6'd0,6'd0 ,6'd4 },
    {1'b1,1'b1,K_L ,6'd6 ,6'd0 ,6'd0,6'd0 ,6'd0 },
    {1'b1,1'b0,K_L ,6'd0 ,6'd1 ,6'd0,6'd0 ,6'd0 },
    {1'b1,1'b0,K_L ,6'd0 ,6'd3 ,6'd0,6'd0 ,6'd0 },
    {1'b1,1'b0,K_L ,6'd0 ,6'd0 ,6'd0,6'd5 ,6'd0 },
    {1'b1,1'b0,K_L ,6'd0 ,6'd0 ,6'd0,6'd6 ,6'd0 },
    {1'b0,1'b0,K_L ,6'd0 ,6'd6 ,6'd2,6'd0 ,6'd0 },
    {1'b0,1'b0,K_L ,6'd0 ,6'd0 ,6'd4,6'd0 ,6'd0 },
    {1'b0,1'b1,K_S ,6'd7 ,6'd0 ,6'd0,6'd0 ,6'd0 },
    {1'b0,1'b1,K_SB,6'd8 ,6'd0 ,6'd0,6'd0 ,6'd7 },
    {1'b0,1'b1,K_S ,6'd9 ,6'd0 ,6'd0,6'd0 ,6'd0 },
    {1'b0,1'b1,K_L ,6'd10,6'd0 ,6'd0,6'd0 ,6'd0 },
    {1'b0,1'b0,K_L ,6'd0 ,6'd0 ,6'd0,6'd0 ,6'd0 },
    {1'b1,1'b0,K_L ,6'd0 ,6'd0 ,6'd0,6'd10,6'd0 },
    {1'b0,1'b0,K_L ,6'd0 ,6'd0 ,6'd7,6'd0 ,6'd0 },
    {1'b0,1'b0,K_L ,6'd0 ,6'd0 ,6'd0,6'd0 ,6'd8 },
    {1'b0,1'b0,K_L ,6'd0 ,6'd0 ,6'd0,6'd0 ,6'd9 },
    {1'b0,1'b0,K_L ,6'd0 ,6'd10,6'd9,6'd0 ,6'd0 },
    {1'b0,1'b1,K_L ,6'd11,6'd0 ,6'd0,6'd0 ,6'd0 },
    {1'b0,1'b1,K_FB,6'd12,6'd0 ,6'd0,6'd11,6'd0 },
    {1'b0,1'b1,K_S ,6'd13,6'd0 ,6'd0,6'd0 ,6'd0 },
    {1'b0,1'b1,K_L ,6'd14,6'd0 ,6'd0,6'd0 ,6'd0 },
    {1'b0,1'b0,K_L ,6'd0 ,6'd11,6'd0,6'd0 ,6'd0 },
    {1'b0,1'b0,K_L ,6'd0 ,6'd0 ,6'd0,6'd12,6'd12},
    {1'b0,1'b0,K_L ,6'd0 ,6'd0 ,6'd0,6'd0 ,6'd13},
    {1'b0,1'b0,K_L ,6'd0 ,6'd0 ,6'd0,6'd14,6'd0 },
    {1'b0,1'b0,K_L ,6'd0 ,6'd14,6'd13,6'd0,6'd0 },
    {1'b1,1'b1,K_L ,6'd15,6'd0 ,6'd0,6'd0 ,6'd0 },
    {1'b1,1'b1,K_LB,6'd16,6'd0 ,6'd0,6'd15,6'd0 },
    {1'b1,1'b1,K_L ,6'd17,6'd0 ,6'd0,6'd0 ,6'd0 },
    {1'b1,1'b1,K_L ,6'd18,6'd0 ,6'd0,6'd0 ,6'd0 },
    {1'b1,1'b0,K_L ,6'd0 ,6'd15,6'd0,6'd0 ,6'd0 },
    {1'b1,1'b0,K_L ,6'd0 ,6'd0 ,6'd0,6'd16,6'd0 },
    {1'b1,1'b0,K_L ,6'd0 ,6'd0 ,6'd0,6'd17,6'd0 },
    {1'b1,1'b0,K_L ,6'd0 ,6'd0 ,6'd0,6'd18,6'd0 },
    {1'b1,1'b0,K_L ,6'd0 ,6'd17,6'd0,6'd0 ,6'd0 },
    {1'b1,1'b0,K_L ,6'd0 ,6'd18,6'd0,6'd0 ,6'd0 }
  };

  logic       clk = 1'b0, rst_n = 1'b0, no_alias = 1'b1;
  logic       alloc_valid = 1'b0, alloc_may_load = 1'b0, alloc_may_store = 1'b0, alloc_side_effect = 1'b0;
  logic [5:0] alloc_age = '0;
  logic [7:0] ld_done = '0, st_done = '0;
  logic [7:0] ld_grant, st_grant, u1_ld_grant, u1_st_grant;
  logic [5:0] ld_grant_age, st_grant_age, u1_ld_age, u1_st_age;
  logic       lq_full, sq_full, u1_lq_full, u1_sq_full;
  logic [7:0] ld_mask [64];
  logic [7:0] st_mask [64];
  logic       bad_seen = 1'b0;
  int         checks = 0, errors = 0;

  always #2 clk = ~clk;

  mem_order_unit u0 (
    .clk(clk), .rst_n(rst_n), .no_alias(no_alias), .alloc_valid(alloc_valid),
    .alloc_may_load(alloc_may_load), .alloc_may_store(alloc_may_store),
    .alloc_side_effect(alloc_side_effect), .alloc_age(alloc_age),
    .ld_done(ld_done), .st_done(st_done), .ld_grant(ld_grant), .ld_grant_age(ld_grant_age),
    .st_grant(st_grant), .st_grant_age(st_grant_age), .lq_full(lq_full), .sq_full(sq_full));

  mem_order_unit #(.LQ_CAP(3)) u1 (
    .clk(clk), .rst_n(rst_n), .no_alias(no_alias), .alloc_valid(alloc_valid),
    .alloc_may_load(alloc_may_load), .alloc_may_store(alloc_may_store),
    .alloc_side_effect(alloc_side_effect), .alloc_age(alloc_age),
    .ld_done(ld_done), .st_done(st_done), .ld_grant(u1_ld_grant), .ld_grant_age(u1_ld_age),
    .st_grant(u1_st_grant), .st_grant_age(u1_st_age), .lq_full(u1_lq_full), .sq_full(u1_sq_full));

  task automatic chk(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic step(input logic na, input logic av, input logic [2:0] kind, input logic [5:0] age,
                      input logic [5:0] dl, input logic [5:0] ds, input logic [5:0] el,
                      input logic [5:0] es, input string tag, input bit check);
    @(negedge clk);
    no_alias          = na;
    alloc_valid       = av;
    alloc_may_load    = (kind == K_L) || (kind == K_LB) || (kind == K_FB);
    alloc_may_store   = (kind == K_S) || (kind == K_SB) || (kind == K_FB);
    alloc_side_effect = (kind == K_LB) || (kind == K_SB) || (kind == K_FB);
    alloc_age         = age;
    ld_done           = (dl != 0) ? ld_mask[dl] : '0;
    st_done           = (ds != 0) ? st_mask[ds] : '0;
    #1;
    if (check) begin
      chk(tag, "ld_grant_age", (ld_grant != 0) ? int'(ld_grant_age) : 0, int'(el));
      chk(tag, "st_grant_age", (st_grant != 0) ? int'(st_grant_age) : 0, int'(es));
    end
    if (ld_grant != 0) begin
      ld_mask[ld_grant_age] = ld_grant;
      if (ld_grant_age == 6'd48 || ld_grant_age == 6'd49) bad_seen = 1'b1;
    end
    if (st_grant != 0) st_mask[st_grant_age] = st_grant;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; alloc_valid = 1'b0; ld_done = '0; st_done = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R11: empty after reset
    chk("R11", "ld_grant", int'(ld_grant), 0);
    chk("R11", "st_grant", int'(st_grant), 0);
    chk("R11", "lq_full", int'(lq_full), 0);
    chk("R11", "sq_full", int'(sq_full), 0);
    rst_n = 1'b1;
  endtask

  function automatic string row_tag(input int r);
    if (r < 5)  return "R5";
    if (r < 10) return "R8";
    if (r < 12) return "R10";
    if (r < 17) return "R6";
    if (r < 22) return "R4";
    if (r < 31) return "R7";
    return "R9";
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL R9 watchdog actual=timeout expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int a = 0; a < 64; a++) begin ld_mask[a] = '0; st_mask[a] = '0; end
    do_reset();

    for (int r = 0; r < NROWS; r++)
      step(TAB[r][34], TAB[r][33], TAB[r][32:30], TAB[r][29:24], TAB[r][23:18],
           TAB[r][17:12], TAB[r][11:6], TAB[r][5:0], row_tag(r), 1'b1);

    do_reset();
    // R1: fill the load queue; second instance has a limit of 3
    for (int n = 0; n < 8; n++) begin
      step(1'b1, 1'b1, K_L, 6'(40 + n), 6'd0, 6'd0, 6'd0, 6'd0, "R1", 1'b0);
      if (n == 2) chk("R1", "capped lq_full at 2", int'(u1_lq_full), 0);
      if (n == 3) chk("R1", "capped lq_full at 3", int'(u1_lq_full), 1);
      if (n == 7) chk("R1", "lq_full at 7", int'(lq_full), 0);
    end
    step(1'b1, 1'b1, K_L, 6'd48, 6'd0, 6'd0, 6'd0, 6'd0, "R1", 1'b0);
    chk("R1", "lq_full at 8", int'(lq_full), 1);
    // R2: a full barrier offered while the load queue is full is refused
    step(1'b1, 1'b1, K_FB, 6'd49, 6'd0, 6'd0, 6'd0, 6'd0, "R2", 1'b0);
    chk("R2", "lq_full held", int'(lq_full), 1);
    for (int n = 0; n < 3; n++)
      step(1'b1, 1'b0, K_L, 6'd0, 6'd0, 6'd0, 6'd0, 6'd0, "R2", 1'b0);
    for (int n = 0; n < 8; n++) begin
      step(1'b1, 1'b1, K_S, 6'(50 + n), 6'd0, 6'd0, 6'd0, 6'd0, "R2", 1'b0);
      if (n == 7) chk("R2", "sq_full with 7 stores", int'(sq_full), 0);
    end
    step(1'b1, 1'b0, K_L, 6'd0, 6'd0, 6'd0, 6'd0, 6'd0, "R2", 1'b0);
    chk("R2", "sq_full with 8 stores", int'(sq_full), 1);
    // R10: completions free the slots
    for (int n = 0; n < 8; n++)
      step(1'b1, 1'b0, K_L, 6'd0, 6'(40 + n), 6'(50 + n), 6'd0, 6'd0, "R10", 1'b0);
    step(1'b1, 1'b0, K_L, 6'd0, 6'd0, 6'd0, 6'd0, 6'd0, "R10", 1'b0);
    chk("R10", "lq_full after completion", int'(lq_full), 0);
    chk("R10", "sq_full after completion", int'(sq_full), 0);
    chk("R2", "refused op granted", int'(bad_seen), 0);

    // R3: store waits behind an older ungranted load
    step(1'b1, 1'b1, K_L,  6'd58, 6'd0,  6'd0, 6'd0,  6'd0,  "R3", 1'b1);
    step(1'b1, 1'b1, K_LB, 6'd59, 6'd0,  6'd0, 6'd58, 6'd0,  "R3", 1'b1);
    step(1'b1, 1'b1, K_L,  6'd60, 6'd0,  6'd0, 6'd0,  6'd0,  "R3", 1'b1);
    step(1'b1, 1'b1, K_S,  6'd61, 6'd0,  6'd0, 6'd0,  6'd0,  "R3", 1'b1);
    step(1'b1, 1'b0, K_L,  6'd0,  6'd0,  6'd0, 6'd0,  6'd0,  "R3", 1'b1);
    step(1'b1, 1'b0, K_L,  6'd0,  6'd58, 6'd0, 6'd0,  6'd0,  "R3", 1'b1);
    step(1'b1, 1'b0, K_L,  6'd0,  6'd0,  6'd0, 6'd59, 6'd0,  "R3", 1'b1);
    step(1'b1, 1'b0, K_L,  6'd0,  6'd0,  6'd0, 6'd60, 6'd0,  "R3", 1'b1);
    step(1'b1, 1'b0, K_L,  6'd0,  6'd0,  6'd0, 6'd0,  6'd61, "R3", 1'b1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule